// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Controller

This block runs the external memory cycles of an 8-bit controller core whose low address byte and data byte share a single byte-wide pin group. The core hands it one request at a time: a code fetch, a data read or a data write. Each request carries a 16-bit address and, for writes, a data byte. An external cycle has two phases of equal, parameterised length. In the first phase the address strobe is high and the low address byte is on the shared lines, so an outside transparent latch can hold it. In the second phase the address strobe is low and the shared lines carry data. The high address byte is on its own port for the whole cycle.

Code and data are two separate 64K spaces. Data reads use the read strobe. Data writes use the write strobe. External code fetches use a third strobe, the program-store strobe. When the external-access input is high, code fetches to the bottom 4K are sent to an internal code memory and no pin activity occurs. When that input is low, every code fetch goes out on the pins. A one-clock done pulse returns the read data.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset and whenever idle, `ale` is 0, `ad_oe` is 0, `rd_n`, `wr_n` and `psen_n` are 1, `done` is 0 and `req_ready` is 1.
- R2: For the PHASE_CLKS cycles after a request to the pins is accepted, `ale` is 1, `ad_oe` is 1, `ad_out` equals address bits 7:0, and all three strobes are 1.
- R3: During both phases of an external cycle, `addr_hi` equals address bits 15:8 and does not change.
- R4: A data write (`req_kind` = 2'b10) has a second phase of PHASE_CLKS cycles with `ale` 0, `wr_n` 0, `ad_oe` 1 and `ad_out` equal to the write byte, while `rd_n` and `psen_n` stay 1.
- R5: A data read (`req_kind` = 2'b01 or 2'b11) has a second phase of PHASE_CLKS cycles with `rd_n` 0 and `ad_oe` 0, while `wr_n` and `psen_n` stay 1. The returned `rdata` is the value of `ad_in` in the last cycle of that phase.
- R6: An external code fetch (`req_kind` = 2'b00) has a second phase with `psen_n` 0 and `ad_oe` 0, while `rd_n` and `wr_n` stay 1. The returned `rdata` is `ad_in` from the last cycle of that phase.
- R7: A code fetch with `ext_access` = 1 and address at most 16'h0FFF is served internally. For one cycle `icode_en` is 1 and `icode_addr` equals address bits 11:0, with no `ale` and no strobe. The next cycle gives `done` with `rdata` equal to `icode_data`. With `ext_access` = 0, or with an address of 16'h1000 or above, the fetch goes to the pins.
- R8: `done` is high for exactly one cycle per accepted request. This is the cycle right after the second phase, or right after the internal cycle.
- R9: A request presented while a cycle is in progress (`req_ready` = 0) is ignored. It does not change the pins of the cycle in progress and does not produce a `done`.
- R10: Data reads and writes always go to the pins, whatever the address and `ext_access`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 code fetch, 01 data read, 10 data write, 11 data read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| ext_access | input | 1 | 1 lets low code fetches be served internally |
| req_ready | output | 1 | Idle; a request is taken this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read or fetched byte, valid with done |
| ale | output | 1 | Address latch strobe |
| ad_out | output | 8 | Shared lines, driven value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_in | input | 8 | Shared lines, received value |
| addr_hi | output | 8 | High address byte |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| psen_n | output | 1 | Program-store strobe, active low |
| icode_en | output | 1 | Internal code memory read |
| icode_addr | output | 12 | Internal code memory address |
| icode_data | input | 8 | Internal code memory data |

## Verification
Take the clock edge that accepts a request as edge 0. For a cycle on the pins, the address phase is visible after edges 0 through PHASE_CLKS-1 and the data phase after edges PHASE_CLKS through 2*PHASE_CLKS-1. `done` and `rdata` then appear after edge 2*PHASE_CLKS. For an internal fetch, `icode_en` is visible after edge 0 and `done` after edge 1. The driver task walks these cycles on falling edges and checks the pins in each one. The monitor pops the expected byte from a queue on each falling edge where `done` is high, so a late, early or extra pulse shows up as a mismatch or an unexpected completion.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [1:0] {
    KIND_CODE  = 2'b00,
    KIND_DRD   = 2'b01,
    KIND_DWR   = 2'b10,
    KIND_DRD_B = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_INT  = 2'd3
  } st_e;

  // Code fetch served from on-chip code store?
  function automatic logic to_internal(input kind_e kind, input logic [15:0] addr,
                                       input logic ext_access, input logic [15:0] top);
    return (kind == KIND_CODE) && ext_access && (addr <= top);
  endfunction

  function automatic logic is_write(input kind_e kind);
    return kind == KIND_DWR;
  endfunction

  function automatic logic is_code(input kind_e kind);
    return kind == KIND_CODE;
  endfunction

endpackage

// File: rtl/mbc_route.sv
module mbc_route
  import mbc_pkg::*;
#(
  parameter int INT_AW = 12
) (
  input  kind_e       kind,
  input  logic [15:0] addr,
  input  logic        ext_access,
  output logic        is_int
);
  localparam logic [15:0] INT_TOP = 16'((1 << INT_AW) - 1);

  always_comb is_int = to_internal(kind, addr, ext_access, INT_TOP);
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int PHASE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_is_int,
  output st_e  st,
  output logic accept,
  output logic phase_end,
  output logic done
);
  localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt;

  assign accept    = req_valid && (st == ST_IDLE);
  assign phase_end = ((st == ST_ADDR) || (st == ST_DATA)) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (accept) st <= req_is_int ? ST_INT : ST_ADDR;
        end
        ST_ADDR: begin
          if (phase_end) begin
            st  <= ST_DATA;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (phase_end) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == ST_DATA || $past(st) == ST_INT)); // R8
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int INT_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               st,
  input  logic              accept,
  input  logic              phase_end,
  input  kind_e             req_kind,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  input  logic [7:0]        ad_in,
  input  logic [7:0]        icode_data,
  output logic [7:0]        rdata,
  output logic              ale,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  output logic [7:0]        addr_hi,
  output logic              rd_n,
  output logic              wr_n,
  output logic              psen_n,
  output logic              icode_en,
  output logic [INT_AW-1:0] icode_addr
);
  kind_e       kind_q;
  logic [15:0] addr_q;
  logic [7:0]  wdata_q;

  logic in_addr, in_data, on_pins, data_wr, data_code, data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= KIND_CODE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign in_addr   = (st == ST_ADDR);
  assign in_data   = (st == ST_DATA);
  assign on_pins   = in_addr || in_data;
  assign data_wr   = in_data && is_write(kind_q);
  assign data_code = in_data && is_code(kind_q);
  assign data_rd   = in_data && !is_write(kind_q) && !is_code(kind_q);

  always_comb begin
    ale        = in_addr;
    ad_oe      = in_addr || data_wr;
    ad_out     = in_addr ? addr_q[7:0] : (data_wr ? wdata_q : 8'h00);
    addr_hi    = on_pins ? addr_q[15:8] : 8'h00;
    rd_n       = !data_rd;
    wr_n       = !data_wr;
    psen_n     = !data_code;
    icode_en   = (st == ST_INT);
    icode_addr = addr_q[INT_AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (in_data && phase_end && !is_write(kind_q)) begin
      rdata <= ad_in;
    end else if (st == ST_INT) begin
      rdata <= icode_data;
    end
  end

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && psen_n && ad_oe)); // R2
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA) |-> $stable(addr_hi)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_n, ~wr_n, ~psen_n}) <= 1); // R4
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe); // R5
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    icode_en |-> (!ale && rd_n && wr_n && psen_n)); // R7
  AST_DATA_NEVER_INT: assert property (@(posedge clk) disable iff (!rst_n)
    icode_en |-> is_code(kind_q)); // R10
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int PHASE_CLKS = 3,
  parameter int INT_AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              ext_access,
  output logic              req_ready,
  output logic              done,
  output logic [7:0]        rdata,
  output logic              ale,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  input  logic [7:0]        ad_in,
  output logic [7:0]        addr_hi,
  output logic              rd_n,
  output logic              wr_n,
  output logic              psen_n,
  output logic              icode_en,
  output logic [INT_AW-1:0] icode_addr,
  input  logic [7:0]        icode_data
);
  kind_e kind_in;
  st_e   st;
  logic  is_int, accept, phase_end;

  assign kind_in   = kind_e'(req_kind);
  assign req_ready = (st == ST_IDLE);

  mbc_route #(.INT_AW(INT_AW)) u_route (
    .kind       (kind_in),
    .addr       (req_addr),
    .ext_access (ext_access),
    .is_int     (is_int)
  );

  mbc_seq #(.PHASE_CLKS(PHASE_CLKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_int (is_int),
    .st         (st),
    .accept     (accept),
    .phase_end  (phase_end),
    .done       (done)
  );

  mbc_pins #(.INT_AW(INT_AW)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .accept     (accept),
    .phase_end  (phase_end),
    .req_kind   (kind_in),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .ad_in      (ad_in),
    .icode_data (icode_data),
    .rdata      (rdata),
    .ale        (ale),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .addr_hi    (addr_hi),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .psen_n     (psen_n),
    .icode_en   (icode_en),
    .icode_addr (icode_addr)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && !ad_oe && rd_n && wr_n && psen_n)); // R1
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> !done || !req_ready || $past(phase_end) || $past(icode_en)); // R9
endmodule

// File: tb/test_mux_bus_ctrl.sv
module test_mux_bus_ctrl;
  localparam int PH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ext_access = 1'b0;
  logic        req_ready, done, ale, ad_oe, rd_n, wr_n, psen_n, icode_en;
  logic [7:0]  rdata, ad_out, addr_hi, ad_in, icode_data;
  logic [11:0] icode_addr;

  always #2.5 clk = ~clk;

  mux_bus_ctrl #(.PHASE_CLKS(PH)) i_mux_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .ext_access(ext_access),
    .req_ready(req_ready), .done(done), .rdata(rdata), .ale(ale),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
    .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n), .icode_en(icode_en),
    .icode_addr(icode_addr), .icode_data(icode_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory models: contents computed from the address
  function automatic logic [7:0] code_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] icode_f(input logic [11:0] a);
    return ~a[7:0] ^ {4'h0, a[11:8]};
  endfunction
  function automatic logic [7:0] dflt_f(input logic [7:0] a);
    return a + 8'h11;
  endfunction

  logic [7:0] lat_lo = '0;
  logic [7:0] xmem [256];
  logic [7:0] shadow [256];

  initial for (int i = 0; i < 256; i++) begin
    xmem[i]   = dflt_f(8'(i));
    shadow[i] = dflt_f(8'(i));
  end

  always @(negedge clk) if (ale) lat_lo <= ad_out;
  always @(negedge clk) if (!wr_n) xmem[lat_lo] <= ad_out;

  always_comb begin
    if (!psen_n)    ad_in = code_f({addr_hi, lat_lo});
    else if (!rd_n) ad_in = xmem[lat_lo];
    else            ad_in = 8'h00;
  end
  assign icode_data = icode_f(icode_addr);

  // Scoreboard
  typedef struct { bit use_val; logic [7:0] val; string tag; } exp_t;
  exp_t expq[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8/R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(1'b1, "R8 done", 1, 1);
        if (e.use_val) chk(rdata == e.val, e.tag, rdata, e.val);
      end
    end
  end

  // kind: 0 code, 1 read, 2 write. stray=1 injects a request mid-cycle.
  task automatic do_req(input logic [1:0] kind, input logic [15:0] a,
                        input logic [7:0] wd, input logic ext, input bit stray);
    bit internal;
    exp_t e;
    internal = (kind == 2'b00) && ext && (a <= 16'h0FFF);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    req_valid = 1'b1; req_kind = kind; req_addr = a; req_wdata = wd; ext_access = ext;
    e.use_val = (kind != 2'b10);
    if (internal)           begin e.val = icode_f(a[11:0]); e.tag = "R7 internal rdata"; end
    else if (kind == 2'b00) begin e.val = code_f(a);        e.tag = "R6 code rdata"; end
    else if (kind == 2'b10) begin shadow[a[7:0]] = wd; e.val = 8'h00; e.tag = "R4"; end
    else                    begin e.val = shadow[a[7:0]];   e.tag = "R5 read rdata"; end
    expq.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (internal) begin
      chk(icode_en == 1'b1, "R7 icode_en", icode_en, 1);
      chk(icode_addr == a[11:0], "R7 icode_addr", icode_addr, a[11:0]);
      chk({ale, rd_n, wr_n, psen_n} == 4'b0111, "R7 pins quiet", {ale, rd_n, wr_n, psen_n}, 4'b0111);
      return;
    end
    chk(icode_en == 1'b0, "R7/R10 external", icode_en, 0);
    for (int i = 0; i < PH; i++) begin
      chk({ale, ad_oe, rd_n, wr_n, psen_n} == 5'b11111, "R2 addr phase ctl",
          {ale, ad_oe, rd_n, wr_n, psen_n}, 5'b11111);
      chk(ad_out == a[7:0], "R2 addr low", ad_out, a[7:0]);
      chk(addr_hi == a[15:8], "R3 addr_hi addr phase", addr_hi, a[15:8]);
      chk(req_ready == 1'b0, "R9 busy", req_ready, 0);
      @(negedge clk);
    end
    for (int i = 0; i < PH; i++) begin
      if (stray && i == 0) begin
        req_valid = 1'b1; req_kind = 2'b10; req_addr = 16'hBEEF; req_wdata = 8'h77;
      end
      if (stray && i == 1) req_valid = 1'b0;
      chk(ale == 1'b0, "R2 ale low in data", ale, 0);
      chk(addr_hi == a[15:8], "R3 addr_hi data phase", addr_hi, a[15:8]);
      case (kind)
        2'b10: begin
          chk({ad_oe, rd_n, wr_n, psen_n} == 4'b1101, "R4 write ctl", {ad_oe, rd_n, wr_n, psen_n}, 4'b1101);
          chk(ad_out == wd, "R4 write data", ad_out, wd);
        end
        2'b00: chk({ad_oe, rd_n, wr_n, psen_n} == 4'b0110, "R6 fetch ctl", {ad_oe, rd_n, wr_n, psen_n}, 4'b0110);
        default: chk({ad_oe, rd_n, wr_n, psen_n} == 4'b0011, "R5 read ctl", {ad_oe, rd_n, wr_n, psen_n}, 4'b0011);
      endcase
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk({ale, rd_n, wr_n, psen_n} == 4'b0111, "R8 pins idle at done", {ale, rd_n, wr_n, psen_n}, 4'b0111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({ale, ad_oe, rd_n, wr_n, psen_n, done, req_ready} == 7'b0011101, "R1 reset state",
        {ale, ad_oe, rd_n, wr_n, psen_n, done, req_ready}, 7'b0011101);
    rst_n = 1'b1;
    do_req(2'b10, 16'h1234, 8'hA5, 1'b0, 1'b0);   // R4 write
    do_req(2'b01, 16'h1234, 8'h00, 1'b0, 1'b0);   // R5 read back
    do_req(2'b11, 16'h0042, 8'h00, 1'b1, 1'b0);   // R10 data read low address, ext=1
    do_req(2'b10, 16'h0050, 8'h5C, 1'b1, 1'b0);   // R10 data write low address, ext=1
    do_req(2'b01, 16'h0050, 8'h00, 1'b1, 1'b0);
    do_req(2'b00, 16'h0100, 8'h00, 1'b0, 1'b0);   // R6/R7 ext=0 fetch to pins
    do_req(2'b00, 16'h0100, 8'h00, 1'b1, 1'b0);   // R7 internal
    do_req(2'b00, 16'h0FFF, 8'h00, 1'b1, 1'b0);   // R7 top internal address
    do_req(2'b00, 16'h1000, 8'h00, 1'b1, 1'b0);   // R7 first external address
    do_req(2'b00, 16'hFFFF, 8'h00, 1'b0, 1'b0);
    do_req(2'b10, 16'h2266, 8'h3D, 1'b0, 1'b1);   // R9 stray request mid-cycle
    do_req(2'b01, 16'h2266, 8'h00, 1'b0, 1'b0);
    do_req(2'b01, 16'h33EF, 8'h00, 1'b0, 1'b0);   // R9 stray address location untouched
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R8 all done", expq.size(), 0);
    chk({ale, rd_n, wr_n, psen_n, req_ready} == 5'b01111, "R1 idle at end",
        {ale, rd_n, wr_n, psen_n, req_ready}, 5'b01111);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule